// File: doc/BRIEF.md
# Dual-Bus Drive Select and Status Router

This block sits between a floppy disk controller and four drives that are split over two physical cables. The two lowest-numbered drives hang on an internal bus and the remaining drives hang on an external bus. A host-written latch, which lies outside this block, holds one select bit per drive. From those bits the block decides which bus the controller listens to. It routes that bus's group of status lines to the controller, and it copies every controller output line onto both buses.

The controller expects a head-load-timing input and a ready input. This block does not observe either from the drives. Both are raised whenever any select bit is set, so a selected drive is always taken as loaded and ready. The select bit alone decides which drive responds to the shared outputs, so the outputs need no gating per bus.

Every result leaves through a register clocked by `clk`, with a synchronous active-high reset. The bus split point, the drive count and the widths of the status and output groups are all parameters.

Top module: `dual_bus_drive_sel`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are: `ctl_stat` all zero, `ext_sel_n` high, `head_ld` low, `drv_rdy` low, and both bus output groups all zero.
- R2: One cycle after `drv_sel` is applied, `ext_sel_n` is low exactly when bit 2 or bit 3 of `drv_sel` is set. Bit n selects drive n, and drives 2 and 3 are on the external bus.
- R3: When the decoded external select is active, `ctl_stat` equals `ext_stat` one cycle later.
- R4: When the decoded external select is inactive, `ctl_stat` equals `int_stat` one cycle later. This includes the case where no drive is selected, in which the internal bus is the default.
- R5: `head_ld` is high one cycle after any bit of `drv_sel` is set, and low one cycle after `drv_sel` is zero.
- R6: `drv_rdy` always carries the same value as `head_ld`.
- R7: One cycle after `ctrl_out` is applied, `int_bus_out` and `ext_bus_out` both equal it, whatever the value of `drv_sel`.
- R8: When several select bits are set at once, the external bus is chosen if bit 2 or bit 3 is among them. Otherwise the internal bus is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_sel | input | 4 | One select bit per drive, from the host latch |
| int_stat | input | 4 | Status lines from the internal bus |
| ext_stat | input | 4 | Status lines from the external bus |
| ctrl_out | input | 5 | Controller output lines bound for the drives |
| ctl_stat | output | 4 | Status lines routed to the controller |
| ext_sel_n | output | 1 | Low while an external drive is selected |
| head_ld | output | 1 | Head-load-timing to the controller |
| drv_rdy | output | 1 | Ready to the controller |
| int_bus_out | output | 5 | Controller outputs driven onto the internal bus |
| ext_bus_out | output | 5 | Controller outputs driven onto the external bus |

## Verification
Every result passes through exactly one register. The routed status, the external select, head-load, ready and both bus copies are therefore all due on the first rising edge after an input is applied. The driver changes inputs on the falling edge and pushes one expected record per cycle. The monitor pops that record a short delay after the next rising edge, so it compares each result in the cycle it is due and not one early or late. Reset values are checked while reset is still held.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  // Default geometry: four drives, the low two on the internal cable.
  localparam int unsigned DEF_NUM_DRV = 4;
  localparam int unsigned DEF_INT_DRV = 2;
  localparam int unsigned DEF_STAT_W  = 4;
  localparam int unsigned DEF_CTRL_W  = 5;

  // Combinational decode of the select bits, shared by the submodules.
  typedef struct packed {
    logic pick_ext;  // an external-bus drive is selected
    logic any_sel;   // at least one drive is selected
  } sel_dec_t;
endpackage

// File: rtl/dbs_sel_decode.sv
module dbs_sel_decode
  import dbs_pkg::*;
#(
  parameter int unsigned NUM_DRV = DEF_NUM_DRV,
  parameter int unsigned INT_DRV = DEF_INT_DRV
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DRV-1:0] sel,
  output sel_dec_t           dec,
  output logic               ext_sel_n,
  output logic               head_ld,
  output logic               drv_rdy
);
  localparam int unsigned EXT_DRV = NUM_DRV - INT_DRV;

  logic [EXT_DRV-1:0] ext_bits;
  assign ext_bits = sel[NUM_DRV-1:INT_DRV];

  always_comb begin
    dec.pick_ext = |ext_bits;
    dec.any_sel  = |sel;
  end

  // Head-load and ready sit in separate flops so that each can be placed
  // next to its own controller pin.
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_sel_n <= 1'b1;
      head_ld   <= 1'b0;
      drv_rdy   <= 1'b0;
    end else begin
      ext_sel_n <= ~dec.pick_ext;
      head_ld   <= dec.any_sel;
      drv_rdy   <= dec.any_sel;
    end
  end

  assert_rst_sel_R1: assert property (@(posedge clk)
    $past(rst) |-> (ext_sel_n && !head_ld && !drv_rdy));

  assert_ext_decode_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ext_sel_n == !$past(|sel[NUM_DRV-1:INT_DRV])));

  assert_any_sel_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (head_ld == $past(sel != '0)));

  assert_rdy_hld_R6: assert property (@(posedge clk) disable iff (rst)
    drv_rdy == head_ld);
endmodule

// File: rtl/dbs_stat_mux.sv
module dbs_stat_mux #(
  parameter int unsigned STAT_W = dbs_pkg::DEF_STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pick_ext,
  input  logic [STAT_W-1:0] int_stat,
  input  logic [STAT_W-1:0] ext_stat,
  output logic [STAT_W-1:0] ctl_stat
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) ctl_stat[i] <= 1'b0;
      else     ctl_stat[i] <= pick_ext ? ext_stat[i] : int_stat[i];
    end
  end

  assert_route_ext_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pick_ext)) |-> (ctl_stat == $past(ext_stat)));

  assert_route_int_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pick_ext)) |-> (ctl_stat == $past(int_stat)));

  assert_rst_stat_R1: assert property (@(posedge clk)
    $past(rst) |-> (ctl_stat == '0));
endmodule

// File: rtl/dbs_ctrl_fanout.sv
module dbs_ctrl_fanout #(
  parameter int unsigned CTRL_W = dbs_pkg::DEF_CTRL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] int_bus,
  output logic [CTRL_W-1:0] ext_bus
);
  // One flop per line per cable: each cable driver gets a local copy.
  for (genvar i = 0; i < CTRL_W; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        int_bus[i] <= 1'b0;
        ext_bus[i] <= 1'b0;
      end else begin
        int_bus[i] <= ctrl_in[i];
        ext_bus[i] <= ctrl_in[i];
      end
    end
  end

  assert_bus_mirror_R7: assert property (@(posedge clk) disable iff (rst)
    int_bus == ext_bus);

  assert_bus_follow_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ext_bus == $past(ctrl_in)));

  assert_rst_bus_R1: assert property (@(posedge clk)
    $past(rst) |-> (int_bus == '0 && ext_bus == '0));
endmodule

// File: rtl/dual_bus_drive_sel.sv
module dual_bus_drive_sel
  import dbs_pkg::*;
#(
  parameter int unsigned NUM_DRV = DEF_NUM_DRV,
  parameter int unsigned INT_DRV = DEF_INT_DRV,
  parameter int unsigned STAT_W  = DEF_STAT_W,
  parameter int unsigned CTRL_W  = DEF_CTRL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_DRV-1:0] drv_sel,
  input  logic [STAT_W-1:0] int_stat,
  input  logic [STAT_W-1:0] ext_stat,
  input  logic [CTRL_W-1:0] ctrl_out,
  output logic [STAT_W-1:0] ctl_stat,
  output logic              ext_sel_n,
  output logic              head_ld,
  output logic              drv_rdy,
  output logic [CTRL_W-1:0] int_bus_out,
  output logic [CTRL_W-1:0] ext_bus_out
);
  sel_dec_t dec;

  dbs_sel_decode #(.NUM_DRV(NUM_DRV), .INT_DRV(INT_DRV)) u_dec (
    .clk(clk), .rst(rst), .sel(drv_sel), .dec(dec),
    .ext_sel_n(ext_sel_n), .head_ld(head_ld), .drv_rdy(drv_rdy)
  );

  dbs_stat_mux #(.STAT_W(STAT_W)) u_mux (
    .clk(clk), .rst(rst), .pick_ext(dec.pick_ext),
    .int_stat(int_stat), .ext_stat(ext_stat), .ctl_stat(ctl_stat)
  );

  dbs_ctrl_fanout #(.CTRL_W(CTRL_W)) u_fan (
    .clk(clk), .rst(rst), .ctrl_in(ctrl_out),
    .int_bus(int_bus_out), .ext_bus(ext_bus_out)
  );

  // Multi-select: the routed bus must agree with the registered select.
  assert_multi_sel_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !ext_sel_n) |-> (ctl_stat == $past(ext_stat)));
endmodule

// File: tb/sim_dual_bus_drive_sel.sv
module sim_dual_bus_drive_sel;
  localparam time PERIOD = 10ns;

  typedef struct packed {
    logic [3:0] sel;
    logic [3:0] stat;
    logic       ext_n;
    logic       hld;
    logic [4:0] bus;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] drv_sel = '0;
  logic [3:0] int_stat = '0;
  logic [3:0] ext_stat = '0;
  logic [4:0] ctrl_out = '0;
  logic [3:0] ctl_stat;
  logic       ext_sel_n, head_ld, drv_rdy;
  logic [4:0] int_bus_out, ext_bus_out;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t q[$];

  always #(PERIOD/2) clk = ~clk;

  dual_bus_drive_sel u0 (
    .clk(clk), .rst(rst), .drv_sel(drv_sel), .int_stat(int_stat),
    .ext_stat(ext_stat), .ctrl_out(ctrl_out), .ctl_stat(ctl_stat),
    .ext_sel_n(ext_sel_n), .head_ld(head_ld), .drv_rdy(drv_rdy),
    .int_bus_out(int_bus_out), .ext_bus_out(ext_bus_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: apply on the falling edge, predict from the requirements.
  task automatic drive(input logic [3:0] s, input logic [3:0] is,
                       input logic [3:0] es, input logic [4:0] c);
    exp_t e;
    @(negedge clk);
    drv_sel = s; int_stat = is; ext_stat = es; ctrl_out = c;
    e.sel   = s;
    e.ext_n = !(s[2] | s[3]);
    e.stat  = e.ext_n ? is : es;
    e.hld   = (s != 4'd0);
    e.bus   = c;
    q.push_back(e);
  endtask

  // Monitor: result due one rising edge after the drive.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.ext_n ? (e.sel == 0 ? "R4 idle-default" : "R4 internal")
                  : ($countones(e.sel) > 1 ? "R8 multi-ext" : "R3 external"),
          {4'd0, ctl_stat}, {4'd0, e.stat});
      chk($countones(e.sel) > 1 ? "R8 ext_sel_n" : "R2 ext_sel_n",
          {7'd0, ext_sel_n}, {7'd0, e.ext_n});
      chk("R5 head_ld", {7'd0, head_ld}, {7'd0, e.hld});
      chk("R6 drv_rdy", {7'd0, drv_rdy}, {7'd0, e.hld});
      chk("R7 int_bus_out", {3'd0, int_bus_out}, {3'd0, e.bus});
      chk("R7 ext_bus_out", {3'd0, ext_bus_out}, {3'd0, e.bus});
    end
  end

  initial begin
    // R1: drive non-zero inputs under reset, outputs must hold reset values.
    drv_sel = 4'hF; int_stat = 4'hA; ext_stat = 4'h5; ctrl_out = 5'h1F;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ctl_stat", {4'd0, ctl_stat}, 8'd0);
    chk("R1 ext_sel_n", {7'd0, ext_sel_n}, 8'd1);
    chk("R1 head_ld", {7'd0, head_ld}, 8'd0);
    chk("R1 drv_rdy", {7'd0, drv_rdy}, 8'd0);
    chk("R1 buses", {3'd0, int_bus_out | ext_bus_out}, 8'd0);
    @(negedge clk);
    rst = 1'b0;

    // Every select pattern, with distinct status on each bus.
    for (int s = 0; s < 16; s++)
      drive(4'(s), 4'(s ^ 4'h9), 4'(~s), 5'(s * 3 + 1));
    // Opposite status patterns and shared outputs held while select changes.
    for (int s = 15; s >= 0; s--)
      drive(4'(s), 4'h3, 4'hC, 5'h15);
    // Back-to-back bus flips.
    drive(4'b0001, 4'h1, 4'hE, 5'h0A);
    drive(4'b0100, 4'h1, 4'hE, 5'h0A);
    drive(4'b0010, 4'h7, 4'h8, 5'h11);
    drive(4'b1000, 4'h7, 4'h8, 5'h11);
    drive(4'b0000, 4'hF, 4'h0, 5'h1F);
    drive(4'b1010, 4'h2, 4'hD, 5'h00);
    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule